// File: doc/BRIEF.md
# Text-Mode Character Display Controller

This block drives a 640x480 raster from a clock that runs at the pixel rate, nominally 25 MHz. It shows an 80 by 30 grid of characters, with each glyph 8 pixels wide and 16 scan lines tall. Two free-running counters, one for the pixel position and one for the line, produce active-low horizontal and vertical sync and a blanking flag. During the active part of each scan line the block reads character codes from an external character RAM. It then reads the matching glyph rows from an external font ROM and sends them out one bit per clock.

Both memories are simple synchronous reads with one cycle of latency. The block issues each character read three clocks before the cell's first pixel and each font read two clocks before it. The byte that comes back is loaded into an 8-bit shift register on the last clock before the cell starts, so the first pixel of a line appears on the first visible clock. No other alignment logic is needed around the memories.

Top module: `vga_text_ctrl`

## Requirements
- R1: A scan line lasts 800 clocks. `hSyncN` is low for positions 0 to 95 and high for positions 96 to 799. Position 0 is the first clock after reset is released.
- R2: A frame has 525 lines. `vSyncN` is low for all of lines 10 and 11 and high on every other line, so it changes level only at position 0 of a line.
- R3: `blank` is low only when the position is 144 to 783 and the line is 45 to 524. It is high during the porches, during either sync and on the 45 lines at the top of the frame.
- R4: `pixel` is 0 whenever `blank` is high.
- R5: Each visible line is split into 80 cells of 8 clocks, with cell c starting at position 144+8c. The cell shows one font byte, most significant bit first. The memories are modelled with one clock of read latency.
- R6: The font read address is the character code times 16 plus the scan line within the character row. That scan line is (line-45) mod 16.
- R7: Cell c of character row r reads character address r*80+c, where r is (line-45)/16. The base address of a row therefore moves up by 80 after its 16 scan lines.
- R8: While `rstN` is low, `hSyncN` is low, `vSyncN` is high, `blank` is high and `pixel` is 0. After release the raster starts again at line 0, position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rstN | input | 1 | Synchronous reset, active low |
| charAddr | output | 12 | Character RAM read address |
| charCode | input | 8 | Character RAM read data, one clock after the address |
| fontAddr | output | 12 | Font ROM read address |
| fontData | input | 8 | Font ROM read data, one clock after the address |
| hSyncN | output | 1 | Horizontal sync, active low |
| vSyncN | output | 1 | Vertical sync, active low |
| blank | output | 1 | High outside the visible area |
| pixel | output | 1 | Serial pixel data |

## Verification
The hardest condition to reach is the change of character row: the row base must advance by 80 and the scan line must wrap to 0 at the same line boundary. Seeing it takes 61 lines of raster, which is close to 49,000 clocks. The bench runs the clock that far and compares every pixel of the last scan line of row 0 and the first scan line of row 1. Its memory models derive their contents from the address, so any misrouted address produces a different bit pattern. The first visible line is also compared pixel by pixel, which shows whether the two-stage fetch lands exactly on position 144.

// File: rtl/vga_text_pkg.sv
package vga_text_pkg;

  // Strobes passed from the timing control to the datapath.
  typedef struct packed {
    logic charFetch;   // character address is presented this cycle
    logic loadShift;   // font byte arrives; load shift register
    logic lineEnd;     // last cycle of a scan line
    logic frameEnd;    // last cycle of the frame
    logic activeLine;  // current line lies in the visible region
  } vgaStrobes_t;

endpackage

// File: rtl/vga_text_timing.sv
module vga_text_timing
  import vga_text_pkg::*;
#(
  parameter int H_SYNC  = 96,
  parameter int H_BACK  = 48,
  parameter int H_FRONT = 16,
  parameter int V_PRE   = 10,
  parameter int V_SYNC  = 2,
  parameter int V_POST  = 33,
  parameter int COLS    = 80,
  parameter int ROWS    = 30,
  parameter int FONT_H  = 16,
  parameter int CELL_W  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  output vgaStrobes_t strb,
  output logic        hSyncN,
  output logic        vSyncN,
  output logic        blank
);

  localparam int H_ACT       = COLS * CELL_W;
  localparam int H_ACT_START = H_SYNC + H_BACK;
  localparam int H_ACT_END   = H_ACT_START + H_ACT;
  localparam int H_TOTAL     = H_ACT_END + H_FRONT;
  localparam int V_SYNC_END  = V_PRE + V_SYNC;
  localparam int V_ACT_START = V_SYNC_END + V_POST;
  localparam int V_TOTAL     = V_ACT_START + ROWS * FONT_H;
  localparam int HW          = $clog2(H_TOTAL);
  localparam int VW          = $clog2(V_TOTAL);
  // Character read, font read, shift load: three stages ahead of pixel.
  localparam int FETCH_LEAD  = 3;
  localparam int FETCH_START = H_ACT_START - FETCH_LEAD;
  localparam int PH_W        = $clog2(CELL_W);

  logic [HW-1:0]   hCount;
  logic [VW-1:0]   vCount;
  logic [HW-1:0]   fetchOffs;
  logic [PH_W-1:0] phase;
  logic            lineDone, hActive, vActive, inWindow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCount <= '0;
      vCount <= '0;
    end else if (lineDone) begin
      hCount <= '0;
      vCount <= (vCount == VW'(V_TOTAL - 1)) ? '0 : vCount + 1'b1;
    end else begin
      hCount <= hCount + 1'b1;
    end
  end

  always_comb begin
    lineDone  = (hCount == HW'(H_TOTAL - 1));
    hActive   = (hCount >= HW'(H_ACT_START)) && (hCount < HW'(H_ACT_END));
    vActive   = (vCount >= VW'(V_ACT_START));
    inWindow  = (hCount >= HW'(FETCH_START)) && (hCount < HW'(FETCH_START + H_ACT));
    fetchOffs = hCount - HW'(FETCH_START);
    phase     = fetchOffs[PH_W-1:0];

    strb.charFetch  = vActive && inWindow && (phase == PH_W'(0));
    strb.loadShift  = vActive && inWindow && (phase == PH_W'(FETCH_LEAD - 1));
    strb.lineEnd    = lineDone;
    strb.frameEnd   = lineDone && (vCount == VW'(V_TOTAL - 1));
    strb.activeLine = vActive;

    hSyncN = !(hCount < HW'(H_SYNC));
    vSyncN = !((vCount >= VW'(V_PRE)) && (vCount < VW'(V_SYNC_END)));
    blank  = !(hActive && vActive);
  end

endmodule

// File: rtl/vga_text_datapath.sv
module vga_text_datapath
  import vga_text_pkg::*;
#(
  parameter int COLS    = 80,
  parameter int FONT_H  = 16,
  parameter int CELL_W  = 8,
  parameter int CODE_W  = 8,
  parameter int CHAR_AW = 12,
  parameter int FONT_AW = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  vgaStrobes_t        strb,
  input  logic               blank,
  input  logic [CODE_W-1:0]  charCode,
  input  logic [CELL_W-1:0]  fontData,
  output logic [CHAR_AW-1:0] charAddr,
  output logic [FONT_AW-1:0] fontAddr,
  output logic               pixel
);

  localparam int COL_W  = $clog2(COLS + 1);
  localparam int LINE_W = $clog2(FONT_H);

  logic [COL_W-1:0]   colIdx;
  logic [LINE_W-1:0]  scanLine;
  logic [CHAR_AW-1:0] rowBase;
  logic [CELL_W-1:0]  shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colIdx <= '0;
    end else if (strb.lineEnd) begin
      colIdx <= '0;
    end else if (strb.charFetch) begin
      colIdx <= colIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.frameEnd) begin
      scanLine <= '0;
      rowBase  <= '0;
    end else if (strb.lineEnd && strb.activeLine) begin
      if (scanLine == LINE_W'(FONT_H - 1)) begin
        scanLine <= '0;
        rowBase  <= rowBase + CHAR_AW'(COLS);
      end else begin
        scanLine <= scanLine + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.loadShift) begin
      shiftReg <= fontData;
    end else begin
      shiftReg <= {shiftReg[CELL_W-2:0], 1'b0};
    end
  end

  always_comb begin
    charAddr = rowBase + CHAR_AW'(colIdx);
    fontAddr = FONT_AW'({charCode, scanLine});
    pixel    = shiftReg[CELL_W-1] && !blank;
  end

endmodule

// File: rtl/vga_text_ctrl.sv
module vga_text_ctrl
  import vga_text_pkg::*;
#(
  parameter int H_SYNC  = 96,
  parameter int H_BACK  = 48,
  parameter int H_FRONT = 16,
  parameter int V_PRE   = 10,
  parameter int V_SYNC  = 2,
  parameter int V_POST  = 33,
  parameter int COLS    = 80,
  parameter int ROWS    = 30,
  parameter int FONT_H  = 16,
  parameter int CELL_W  = 8,
  parameter int CODE_W  = 8,
  parameter int CHAR_AW = $clog2(COLS * ROWS),
  parameter int FONT_AW = CODE_W + $clog2(FONT_H)
) (
  input  logic               clk,
  input  logic               rstN,
  output logic [CHAR_AW-1:0] charAddr,
  input  logic [CODE_W-1:0]  charCode,
  output logic [FONT_AW-1:0] fontAddr,
  input  logic [CELL_W-1:0]  fontData,
  output logic               hSyncN,
  output logic               vSyncN,
  output logic               blank,
  output logic               pixel
);

  vgaStrobes_t strb;

  vga_text_timing #(
    .H_SYNC(H_SYNC), .H_BACK(H_BACK), .H_FRONT(H_FRONT),
    .V_PRE(V_PRE), .V_SYNC(V_SYNC), .V_POST(V_POST),
    .COLS(COLS), .ROWS(ROWS), .FONT_H(FONT_H), .CELL_W(CELL_W)
  ) u_timing (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hSyncN(hSyncN), .vSyncN(vSyncN), .blank(blank)
  );

  vga_text_datapath #(
    .COLS(COLS), .FONT_H(FONT_H), .CELL_W(CELL_W),
    .CODE_W(CODE_W), .CHAR_AW(CHAR_AW), .FONT_AW(FONT_AW)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .blank(blank),
    .charCode(charCode), .fontData(fontData),
    .charAddr(charAddr), .fontAddr(fontAddr), .pixel(pixel)
  );

endmodule

// File: rtl/vga_text_ctrl_chk.sv
module vga_text_ctrl_chk #(
  parameter int H_SYNC  = 96,
  parameter int H_TOTAL = 800
) (
  input logic clk,
  input logic rstN,
  input logic hSyncN,
  input logic vSyncN,
  input logic blank,
  input logic pixel
);

  logic prevHs, seenFall, fallNow, riseNow;
  int   sinceFall;

  assign fallNow = prevHs && !hSyncN;
  assign riseNow = !prevHs && hSyncN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevHs    <= 1'b0;
      seenFall  <= 1'b0;
      sinceFall <= 0;
    end else begin
      prevHs <= hSyncN;
      if (fallNow) begin
        seenFall  <= 1'b1;
        sinceFall <= 1;
      end else begin
        sinceFall <= sinceFall + 1;
      end
    end
  end

  assert_line_period_R1: assert property (@(posedge clk) disable iff (!rstN)
    (fallNow && seenFall) |-> (sinceFall == H_TOTAL));

  assert_sync_width_R1: assert property (@(posedge clk) disable iff (!rstN)
    (riseNow && seenFall) |-> (sinceFall == H_SYNC));

  assert_vsync_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vSyncN) |-> fallNow);

  assert_sync_blank_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!hSyncN || !vSyncN) |-> blank);

  assert_pixel_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    blank |-> !pixel);

endmodule

bind vga_text_ctrl vga_text_ctrl_chk #(
  .H_SYNC(H_SYNC),
  .H_TOTAL(H_SYNC + H_BACK + COLS * CELL_W + H_FRONT)
) u_chk (
  .clk(clk), .rstN(rstN), .hSyncN(hSyncN), .vSyncN(vSyncN),
  .blank(blank), .pixel(pixel)
);

// File: tb/vga_text_ctrl_tb.sv
module vga_text_ctrl_tb;

  localparam int CLK_PERIOD = 40;
  localparam int LINE       = 800;
  localparam int NVEC       = 12;

  typedef struct packed {
    int   cyc;
    logic hs;
    logic vs;
    logic bl;
  } vec_t;

  // Probe points on the raster: absolute cycle since release, expected
  // hSyncN, vSyncN, blank (R1 line timing, R2 vertical sync, R3 blanking).
  localparam vec_t VECS [NVEC] = '{
    '{0,    1'b0, 1'b1, 1'b1},   // R1 sync starts the line
    '{95,   1'b0, 1'b1, 1'b1},   // R1 last sync clock
    '{96,   1'b1, 1'b1, 1'b1},   // R1 back porch begins
    '{143,  1'b1, 1'b1, 1'b1},   // R3 last back porch clock
    '{144,  1'b1, 1'b1, 1'b1},   // R3 vertical blank line stays blank
    '{799,  1'b1, 1'b1, 1'b1},   // R1 last clock of line 0
    '{800,  1'b0, 1'b1, 1'b1},   // R1 line 1 sync
    '{7999, 1'b1, 1'b1, 1'b1},   // R2 end of line 9
    '{8000, 1'b0, 1'b0, 1'b1},   // R2 vertical sync starts line 10
    '{9599, 1'b1, 1'b0, 1'b1},   // R2 still low at end of line 11
    '{9600, 1'b0, 1'b1, 1'b1},   // R2 released at line 12
    '{9700, 1'b1, 1'b1, 1'b1}    // R3 porch on line 12
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [11:0] charAddr, fontAddr;
  logic [7:0]  charCode, fontData;
  logic        hSyncN, vSyncN, blank, pixel;
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  vga_text_ctrl u_dut (
    .clk(clk), .rstN(rstN), .charAddr(charAddr), .charCode(charCode),
    .fontAddr(fontAddr), .fontData(fontData), .hSyncN(hSyncN),
    .vSyncN(vSyncN), .blank(blank), .pixel(pixel)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] codeOf(input int a);
    return 8'((a * 7 + 3) ^ (a >> 4));
  endfunction

  function automatic logic [7:0] fontOf(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  // Synchronous memory models, one clock of read latency.
  always @(posedge clk) begin
    charCode <= codeOf(int'(charAddr));
    fontData <= fontOf(int'(fontAddr));
  end

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  function automatic logic expBlank(input int l, input int h);
    return !(l >= 45 && h >= 144 && h < 784);
  endfunction

  function automatic logic expPix(input int l, input int h);
    int r, s, col, bitPos;
    logic [7:0] glyph;
    if (expBlank(l, h)) return 1'b0;
    r      = (l - 45) / 16;
    s      = (l - 45) % 16;
    col    = (h - 144) / 8;
    bitPos = 7 - ((h - 144) % 8);
    glyph  = fontOf(int'(codeOf(r * 80 + col)) * 16 + s);
    return glyph[bitPos];
  endfunction

  task automatic goTo(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic checkOut(input string tag, input logic eHs, input logic eVs,
                          input logic eBl, input logic ePx);
    checks++;
    if (hSyncN !== eHs || vSyncN !== eVs || blank !== eBl || pixel !== ePx) begin
      errors++;
      $display("FAIL %s cyc %0d hs/vs/blank/pixel got %b%b%b%b exp %b%b%b%b",
               tag, cyc, hSyncN, vSyncN, blank, pixel, eHs, eVs, eBl, ePx);
    end
  endtask

  task automatic checkLine(input int l, input string tag);
    int pixBad = 0;
    int tmBad = 0;
    for (int h = 0; h < LINE; h++) begin
      logic ePx, eBl, eHs, eVs;
      goTo(l * LINE + h);
      ePx = expPix(l, h);
      eBl = expBlank(l, h);
      eHs = (h >= 96);
      eVs = !(l == 10 || l == 11);
      if (pixel !== ePx) begin
        if (pixBad == 0)
          $display("FAIL %s line %0d pos %0d pixel got %b exp %b", tag, l, h, pixel, ePx);
        pixBad++;
      end
      if (blank !== eBl || hSyncN !== eHs || vSyncN !== eVs) begin
        if (tmBad == 0)
          $display("FAIL R3 line %0d pos %0d blank/hs/vs got %b%b%b exp %b%b%b",
                   l, h, blank, hSyncN, vSyncN, eBl, eHs, eVs);
        tmBad++;
      end
    end
    checks += 2;
    if (pixBad != 0) errors++;
    if (tmBad != 0) errors++;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cyc %0d got running exp finished", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    checkOut("R8", 1'b0, 1'b1, 1'b1, 1'b0);   // R8 state in reset
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      goTo(VECS[i].cyc);
      checkOut("R1R2R3", VECS[i].hs, VECS[i].vs, VECS[i].bl, 1'b0);
    end

    checkLine(44, "R4");   // last vertical blank line: pixel stays 0
    checkLine(45, "R5");   // first visible line, fetch alignment, MSB first
    checkLine(46, "R6");   // scan line 1 of row 0
    checkLine(60, "R6");   // scan line 15 of row 0
    checkLine(61, "R7");   // row 1: base advanced by 80, scan line wrapped

    // R8: reset in mid-frame, then the raster restarts at line 0
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkOut("R8", 1'b0, 1'b1, 1'b1, 1'b0);
    rstN = 1'b1;
    goTo(96);
    checkOut("R8", 1'b1, 1'b1, 1'b1, 1'b0);
    goTo(7999);
    checkOut("R8", 1'b1, 1'b1, 1'b1, 1'b0);
    goTo(8000);
    checkOut("R8", 1'b0, 1'b0, 1'b1, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule